// File: doc/BRIEF.md
# Receive Descriptor Writeback Engine

This block sits on the receive side of a network controller. It takes incoming frames as a byte stream and holds each frame in an internal frame store. It also checks the destination address of the frame. A frame that passes is copied into system memory as 32-bit words, at the buffer address named by the current receive descriptor. Once the copy is complete, the engine writes the final length and status back into that descriptor.

Receive descriptors are pairs of words in a shared descriptor RAM. The first word of a pair is status and the second is the buffer address. The receive ring starts at a programmable split index, which is the count of descriptors reserved for transmit, and it wraps back to that index. A frame that arrives while the current descriptor is still owned by software is consumed and discarded, and a busy event is signalled. Interrupt requests are raised for busy and for completed frames, each gated by its own mask input.

Top module: `rx_desc_engine`

## Requirements
- R1: After reset `in_ready` and `mem_we` are low and `bd_idx` equals `split_idx`. While `rx_en` is low and the engine is idle, no byte is accepted.
- R2: A descriptor is taken for reception when bit 15 (ready) of its status word is set. The engine then captures the buffer address from the following RAM word.
- R3: A frame that arrives while the current descriptor has bit 15 clear is accepted byte by byte and thrown away. It produces exactly one `busy_set` pulse, and `irq` pulses with it when `mask_busy` is high. Nothing is written and the descriptor index does not move.
- R4: A frame shorter than `HDR_LEN` (14) bytes is dropped. It causes no memory write and no descriptor change, and the same descriptor receives the next frame.
- R5: When `promisc` is low, received byte i (for i from 0 to 5) must equal `station_addr[8*(5-i)+7 : 8*(5-i)]`. Any mismatch drops the frame with no write. When `promisc` is high every frame of legal length is taken.
- R6: Frame data goes out as words to `mem_addr` = buffer + 4k, where k counts from 0 in consecutive cycles. Byte 4k sits in bits 31:24 and byte 4k+3 in bits 7:0. Lanes past the end of the frame are zero.
- R7: In the cycle of the last data word the status word is written back as follows. Bits 31:16 hold the length and bit 15 is cleared. Bits 14:7 are kept from the fetched status and bits 6:2 are cleared. Bit 1 is set when the length exceeds `max_len`, and bit 0 is set when the length is below `min_len`.
- R8: Each writeback comes with one `rxb_set` pulse, and `irq` pulses with it when `mask_rxb` is high.
- R9: After writeback the index returns to `split_idx` if status bit 13 (wrap) was set or the index was at least `BD_WORDS-2`. Otherwise it advances by 2.
- R10: Bytes beyond `MAX_FRAME` are accepted and discarded, and the length reported is `MAX_FRAME`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receive enable |
| promisc | input | 1 | Accept any destination address |
| station_addr | input | 48 | Own station address |
| min_len | input | 16 | Length below which bit 0 is set |
| max_len | input | 16 | Length above which bit 1 is set |
| split_idx | input | IDX_W | First receive descriptor index |
| mask_busy | input | 1 | Interrupt enable for busy events |
| mask_rxb | input | 1 | Interrupt enable for received frames |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Final byte of frame |
| in_ready | output | 1 | Byte accepted when high with in_valid |
| bd_idx | output | IDX_W | Descriptor RAM index of current status word |
| bd_stat | input | 32 | Descriptor RAM word at bd_idx |
| bd_buf | input | 32 | Descriptor RAM word at bd_idx+1 |
| bd_we | output | 1 | Write bd_wdata to RAM word bd_idx |
| bd_wdata | output | 32 | Status word written back |
| mem_we | output | 1 | Memory word write strobe |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| busy_set | output | 1 | Busy event pulse |
| rxb_set | output | 1 | Frame-received event pulse |
| irq | output | 1 | Masked interrupt pulse |

## Verification
The bench builds the engine with `MAX_FRAME` = 64 and `BD_WORDS` = 16, and drives a split index of 4. With these values the ring reaches its upper limit after six frames, so the limit wrap and the flag wrap both appear within a short run. A 70-byte frame is enough to exercise truncation at the frame store. A 64-byte ceiling also keeps frame lengths that straddle the 14-byte floor, `min_len` and `max_len` common in the random mix.

// File: rtl/rx_desc_engine.sv
module rx_desc_engine #(
  parameter int MAX_FRAME = 1536,
  parameter int BD_WORDS  = 128,
  parameter int HDR_LEN   = 14,
  localparam int IDX_W = $clog2(BD_WORDS),
  localparam int CNT_W = $clog2(MAX_FRAME + 1),
  localparam int AW    = $clog2(MAX_FRAME)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             promisc,
  input  logic [47:0]      station_addr,
  input  logic [15:0]      min_len,
  input  logic [15:0]      max_len,
  input  logic [IDX_W-1:0] split_idx,
  input  logic             mask_busy,
  input  logic             mask_rxb,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             in_ready,
  output logic [IDX_W-1:0] bd_idx,
  input  logic [31:0]      bd_stat,
  input  logic [31:0]      bd_buf,
  output logic             bd_we,
  output logic [31:0]      bd_wdata,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  output logic             busy_set,
  output logic             rxb_set,
  output logic             irq
);
  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RECV, S_WRITE} st_t;

  st_t              st;
  logic [IDX_W-1:0] off;
  logic [7:0]       fbuf [MAX_FRAME];
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   wptr;
  logic             hit, mid;
  logic [31:0]      base;
  logic [7:0]       keep;

  wire take   = in_valid && in_ready;
  wire bd_rdy = bd_stat[15];
  logic unused_bits;
  assign unused_bits = ^{bd_stat[31:16], bd_stat[6:0]};

  assign in_ready = (st == S_RECV) || (st == S_WAIT && (!bd_rdy || mid));
  assign busy_set = (st == S_WAIT) && take && !mid && !bd_rdy;

  wire last_wr = (st == S_WRITE) && ((wptr + (CNT_W+1)'(4)) >= {1'b0, cnt});
  assign mem_we   = (st == S_WRITE);
  assign bd_we    = last_wr;
  assign rxb_set  = last_wr;
  assign irq      = (busy_set && mask_busy) || (rxb_set && mask_rxb);
  assign mem_addr = base + 32'(wptr);

  wire [IDX_W:0] cur = {1'b0, split_idx} + {1'b0, off};
  assign bd_idx = cur[IDX_W-1:0];
  wire ring_end = keep[6] || (cur >= (IDX_W+1)'(BD_WORDS - 2));

  wire [CNT_W-1:0] ncnt = (cnt < CNT_W'(MAX_FRAME)) ? cnt + 1'b1 : cnt;
  wire [2:0] asel = (cnt < CNT_W'(6)) ? 3'(3'd5 - cnt[2:0]) : 3'd0;
  wire [7:0] want = station_addr[{asel, 3'b000} +: 8];
  wire       bad  = (cnt < CNT_W'(6)) && (in_data != want);

  wire [15:0] flen = 16'(cnt);
  assign bd_wdata = {flen, 1'b0, keep, 5'b0, flen > max_len, flen < min_len};

  logic [7:0] lane [4];
  for (genvar j = 0; j < 4; j++) begin : g_lane
    wire [CNT_W:0] p = wptr + (CNT_W+1)'(j);
    assign lane[j] = (p < {1'b0, cnt} && p < (CNT_W+1)'(MAX_FRAME)) ? fbuf[p[AW-1:0]] : 8'h00;
  end
  assign mem_wdata = {lane[0], lane[1], lane[2], lane[3]};

  always_ff @(posedge clk)
    if (st == S_RECV && take && cnt < CNT_W'(MAX_FRAME)) fbuf[cnt[AW-1:0]] <= in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; off <= '0; cnt <= '0; wptr <= '0;
      hit <= 1'b1; mid <= 1'b0; base <= '0; keep <= '0;
    end else begin
      case (st)
        S_IDLE: if (rx_en) st <= S_WAIT;
        S_WAIT: begin
          if (take) mid <= !in_last;
          if (!mid) begin
            if (bd_rdy) begin
              base <= bd_buf; keep <= bd_stat[14:7];
              cnt <= '0; hit <= 1'b1; st <= S_RECV;
            end else if (!rx_en) st <= S_IDLE;
          end
        end
        S_RECV: if (take) begin
          if (bad) hit <= 1'b0;
          if (!in_last) cnt <= ncnt;
          else if (ncnt < CNT_W'(HDR_LEN)) begin
            cnt <= '0; hit <= 1'b1; st <= S_IDLE;
          end else if (!promisc && !(hit && !bad)) begin
            cnt <= '0; hit <= 1'b1;
          end else begin
            cnt <= ncnt; wptr <= '0; st <= S_WRITE;
          end
        end
        S_WRITE: begin
          wptr <= wptr + (CNT_W+1)'(4);
          if (last_wr) begin
            off <= ring_end ? '0 : off + IDX_W'(2);
            cnt <= '0; st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> mem_addr == $past(mem_addr) + 32'd4);
  a_r6_write_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> $past(in_valid && in_ready && in_last));
  a_r4_len_floor: assert property (@(posedge clk) disable iff (!rst_n)
    bd_we |-> bd_wdata[31:16] >= 16'(HDR_LEN));
  a_r3_busy_unready: assert property (@(posedge clk) disable iff (!rst_n)
    busy_set |-> !bd_stat[15]);
  a_r8_rxb_wb: assert property (@(posedge clk) disable iff (!rst_n)
    rxb_set |-> (bd_we && mem_we));
  a_r9_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    bd_we |=> (bd_idx == split_idx) || (bd_idx == $past(bd_idx) + IDX_W'(2)));
endmodule

// File: tb/rx_desc_engine_bench.sv
module rx_desc_engine_bench;
  localparam int MF = 64, BDW = 16, IW = 4;
  localparam logic [IW-1:0] SPLIT = 4'd4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic rx_en = 0, promisc = 0, mask_busy = 1, mask_rxb = 1;
  logic [47:0] station = 48'h0A1B2C3D4E5F;
  logic [15:0] min_len = 16'd16, max_len = 16'd60;
  logic in_valid = 0, in_last = 0, in_ready;
  logic [7:0] in_data = 0;
  logic [IW-1:0] bd_idx;
  logic [31:0] bd_stat, bd_buf, bd_wdata, mem_addr, mem_wdata;
  logic bd_we, mem_we, busy_set, rxb_set, irq;

  rx_desc_engine #(.MAX_FRAME(MF), .BD_WORDS(BDW)) u_rx_desc_engine (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .promisc(promisc),
    .station_addr(station), .min_len(min_len), .max_len(max_len),
    .split_idx(SPLIT), .mask_busy(mask_busy), .mask_rxb(mask_rxb),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .bd_idx(bd_idx), .bd_stat(bd_stat), .bd_buf(bd_buf), .bd_we(bd_we), .bd_wdata(bd_wdata),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .busy_set(busy_set), .rxb_set(rxb_set), .irq(irq));

  logic [31:0] bd_ram [0:BDW-1];
  logic [31:0] mem [0:255];
  logic cfg_we = 0;
  logic [IW-1:0] cfg_idx = 0;
  logic [31:0] cfg_val = 0;
  int wr_cnt = 0, rxb_cnt = 0, busy_cnt = 0, irq_cnt = 0;

  assign bd_stat = bd_ram[bd_idx];
  assign bd_buf  = bd_ram[bd_idx + 1'b1];

  always @(posedge clk) begin
    if (cfg_we) bd_ram[cfg_idx] <= cfg_val;
    if (rst_n) begin
      if (bd_we) bd_ram[bd_idx] <= bd_wdata;
      if (mem_we) begin mem[mem_addr[9:2]] <= mem_wdata; wr_cnt <= wr_cnt + 1; end
      if (rxb_set) rxb_cnt <= rxb_cnt + 1;
      if (busy_set) busy_cnt <= busy_cnt + 1;
      if (irq) irq_cnt <= irq_cnt + 1;
    end
  end

  int checks = 0, errors = 0;
  int eidx = 4;
  logic [7:0] fb [0:127];

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%h expected=%h", tag, act, exp); end
  endtask

  task automatic wr_bd(int idx, logic [31:0] val);
    @(negedge clk); cfg_we = 1; cfg_idx = IW'(idx); cfg_val = val;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic build(int len, bit match);
    for (int i = 0; i < len; i++)
      fb[i] = (i < 6 && match) ? station[8*(5-i) +: 8] : 8'($urandom);
    if (!match) fb[0] = station[47:40] ^ 8'h01;
  endtask

  task automatic send(int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk); in_valid = 1; in_data = fb[i]; in_last = (i == len - 1);
      while (!in_ready) @(negedge clk);
    end
    @(negedge clk); in_valid = 0; in_last = 0;
  endtask

  function automatic logic [31:0] expword(int k, int cap);
    logic [31:0] w = 0;
    for (int j = 0; j < 4; j++) w = {w[23:0], (4*k + j < cap) ? fb[4*k + j] : 8'h00};
    return w;
  endfunction

  task automatic run(int len, bit match, bit arm_it, bit wrapf, string tag);
    logic [31:0] old, es;
    int w0, r0, b0, i0, cap, nw, nxt;
    bit acc;
    if (arm_it) wr_bd(eidx, 32'h0000_8C7F | (32'(wrapf) << 13));
    old = bd_ram[eidx];
    w0 = wr_cnt; r0 = rxb_cnt; b0 = busy_cnt; i0 = irq_cnt;
    build(len, match);
    send(len);
    repeat (24) @(negedge clk);
    cap = (len > MF) ? MF : len;
    acc = arm_it && len >= 14 && (promisc || match);
    if (acc) begin
      nw = (cap + 3) / 4;
      for (int k = 0; k < nw; k++)
        chk(mem[eidx*8 + k] == expword(k, cap), {tag, " word"}, mem[eidx*8 + k], expword(k, cap));
      chk(wr_cnt - w0 == nw, {tag, " write count"}, wr_cnt - w0, nw);
      es = {16'(cap), 1'b0, old[14:7], 5'b0, 16'(cap) > max_len, 16'(cap) < min_len};
      chk(bd_ram[eidx] == es, {tag, " R7 status"}, bd_ram[eidx], es);
      chk(rxb_cnt - r0 == 1, {tag, " R8 rxb"}, rxb_cnt - r0, 1);
      chk(irq_cnt - i0 == int'(mask_rxb), {tag, " R8 irq"}, irq_cnt - i0, mask_rxb);
      nxt = (wrapf || eidx >= BDW - 2) ? int'(SPLIT) : eidx + 2;
      chk(bd_idx == IW'(nxt), {tag, " R9 index"}, bd_idx, nxt);
      eidx = nxt;
    end else begin
      chk(wr_cnt == w0, {tag, " no write"}, wr_cnt - w0, 0);
      chk(bd_ram[eidx] == old, {tag, " descriptor kept"}, bd_ram[eidx], old);
      chk(bd_idx == IW'(eidx), {tag, " index kept"}, bd_idx, eidx);
      chk(rxb_cnt == r0, {tag, " no rxb"}, rxb_cnt - r0, 0);
      if (!arm_it) begin
        chk(busy_cnt - b0 == 1, {tag, " R3 busy"}, busy_cnt - b0, 1);
        chk(irq_cnt - i0 == int'(mask_busy), {tag, " R3 irq"}, irq_cnt - i0, mask_busy);
      end
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < BDW; i++) wr_bd(i, (i % 2) ? 32'(((i - 1) * 32)) : 32'h0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(in_ready == 0, "R1 reset in_ready", in_ready, 0);
    chk(mem_we == 0, "R1 reset mem_we", mem_we, 0);
    chk(irq == 0, "R1 reset irq", irq, 0);
    chk(bd_idx == SPLIT, "R1 reset index", bd_idx, SPLIT);
    in_valid = 1; in_data = 8'h55;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); chk(in_ready == 0, "R1 disabled no accept", in_ready, 0);
    end
    in_valid = 0;
    rx_en = 1;
    run(20, 1, 1, 0, "R2 R6 basic");
    run(23, 1, 1, 0, "R6 partial lanes");
    run(30, 0, 1, 0, "R5 mismatch");
    run(10, 1, 1, 0, "R4 short");
    promisc = 1; run(30, 0, 1, 0, "R5 promisc"); promisc = 0;
    run(62, 1, 1, 0, "R7 too long");
    run(15, 1, 1, 0, "R7 too short");
    run(40, 1, 1, 0, "R9 limit");
    run(20, 1, 1, 1, "R9 wrap flag");
    run(20, 1, 0, 0, "R3 busy masked on");
    mask_busy = 0; run(25, 1, 0, 0, "R3 busy masked off"); mask_busy = 1;
    run(20, 1, 1, 0, "R3 after busy");
    run(70, 1, 1, 0, "R10 oversize");
    mask_rxb = 0; run(32, 1, 1, 0, "R8 mask off"); mask_rxb = 1;
    for (int n = 0; n < 10; n++) begin
      promisc = ($urandom % 4) == 0;
      run(10 + int'($urandom % 61), ($urandom % 5) != 0, 1, 0, "R6 random");
    end
    promisc = 0;
    finish_run();
  end
endmodule